// File: doc/BRIEF.md
# Serial Packet Framer with Selectable CRC

This block assembles one over-the-air packet and presents it one bit at a time. A bit is handed out each cycle that the shift enable is high. A start request captures the whole setup at once: an address of 3 to 5 bytes, a payload length of 0 to 32 bytes, a dynamic-length switch, a no-acknowledge flag and a CRC selection. The packet is then sent in this order: a one-byte preamble, the address, an optional 9-bit control word, the payload and the CRC.

The preamble polarity follows the first address bit. The control word is sent only in dynamic-length mode. It carries the length, a 2-bit packet identifier and the no-acknowledge flag. The CRC can be off, one byte wide or two bytes wide. Its register starts at all ones and covers everything after the preamble.

Payload bytes are fetched through a combinational read port. The block drives a byte index, and the storage next to it returns that byte in the same cycle. The packet identifier is held inside the block. It advances for each new payload and is reused when a resend is requested.

Top module: `pkt_framer`

## Requirements
- R1: The first 8 bits of every packet are the preamble. It is 10101010 when the first address bit is 1 and 01010101 when that bit is 0.
- R2: The address code `aw_code` selects the address length: 2'b10 gives 4 bytes, 2'b11 gives 5 bytes, and 2'b01 or 2'b00 give 3 bytes. The address is taken from the low bytes of `addr` and sent from bit 8*n-1 down to bit 0.
- R3: When `dyn_len` is 1, 9 control bits follow the address. Sent MSB first, they are the 6-bit length, then the 2-bit packet identifier, then `no_ack`. When `dyn_len` is 0, no control bits are sent.
- R4: `pay_len` bytes of payload follow. Any value above 32 is treated as 32. Byte k is read at `pay_idx` = k and sent MSB first, unmodified.
- R5: When `crc_sel` = 2'b01, an 8-bit CRC follows the payload. It uses polynomial x^8+x^2+x+1, starts at 0xFF and is sent MSB first.
- R6: When `crc_sel[1]` = 1, a 16-bit CRC follows the payload. It uses polynomial x^16+x^12+x^5+1 and starts at 0xFFFF. When `crc_sel` = 2'b00, no CRC is sent. Either CRC covers the address, the control bits and the payload, but not the preamble.
- R7: `tx_done` is high for exactly one cycle, the cycle after the last bit of the packet is taken. In that cycle `tx_valid` is already low.
- R8: While `tx_valid` is high, one bit is taken at each rising edge with `bit_en` high. The bit and its position are held while `bit_en` is low. `bit_en` has no effect while the block is idle.
- R9: A start request while `tx_valid` is high is ignored. It changes neither the packet in progress nor the packet identifier.
- R10: The packet identifier is 0 after reset. It advances by one, modulo 4, before each start with `resend` = 0. A start with `resend` = 1 reuses the previous value.
- R11: After reset, `tx_valid`, `tx_done` and `tx_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Take the current bit at this edge |
| start | input | 1 | Begin a packet; accepted only when idle |
| resend | input | 1 | Reuse the previous packet identifier |
| addr | input | 40 | Address; the low bytes are used |
| aw_code | input | 2 | Address length code |
| dyn_len | input | 1 | Send the control word |
| no_ack | input | 1 | Flag placed in the control word |
| crc_sel | input | 2 | 00 none, 01 8-bit, 1x 16-bit |
| pay_len | input | 6 | Payload bytes, capped at 32 |
| pay_byte | input | 8 | Payload byte at `pay_idx` |
| pay_idx | output | 5 | Index of the payload byte being sent |
| tx_bit | output | 1 | Current serial bit |
| tx_valid | output | 1 | A packet is being sent |
| tx_done | output | 1 | One-cycle pulse after the last bit |

## Verification
- **Start and first bit.** A start request is registered, so `tx_valid` and the first preamble bit appear one cycle after the start edge. All inputs are driven on falling edges, and outputs are sampled on falling edges.
- **Bit capture.** Each bit is recorded at the falling edge just before the rising edge where `bit_en` takes it. The recorded stream is compared with a packet built in the bench from the requirements, including its own bitwise CRC.
- **Done pulse.** `tx_done` must be seen at exactly the falling edge one cycle after the last bit was taken, and never in another cycle.
- **Ignored inputs.** A start during a packet and `bit_en` pulses while idle are shown to have no effect in two ways: through the stream itself, and through the packet identifier carried in the next packet's control word.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int ADDR_MAX_BYTES = 5;
    localparam int ADDR_BITS      = ADDR_MAX_BYTES * 8;
    localparam int PAY_MAX_BYTES  = 32;
    localparam int LEN_W          = 6;
    localparam int PID_W          = 2;
    localparam int CTRL_BITS      = LEN_W + PID_W + 1;
    localparam int CNT_W          = $clog2(PAY_MAX_BYTES * 8 + 1);
    localparam int PIDX_W         = $clog2(PAY_MAX_BYTES);
    localparam int AB_W           = $clog2(ADDR_MAX_BYTES + 1);
    localparam int CRC_W          = 16;
    localparam logic [15:0] POLY16 = 16'h1021;
    localparam logic [7:0]  POLY8  = 8'h07;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_PRE,
        SEG_ADDR,
        SEG_CTRL,
        SEG_PAY,
        SEG_CRC
    } seg_e;

    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic [AB_W-1:0]      addr_bytes;
        logic                 dyn;
        logic                 no_ack;
        logic [1:0]           crc_sel;
        logic [LEN_W-1:0]     len;
        logic [PID_W-1:0]     pid;
    } frame_cfg_t;

    function automatic logic [AB_W-1:0] aw_bytes(input logic [1:0] code);
        case (code)
            2'b10:   return AB_W'(4);
            2'b11:   return AB_W'(5);
            default: return AB_W'(3);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (int'(l) > PAY_MAX_BYTES) ? LEN_W'(PAY_MAX_BYTES) : l;
    endfunction

    // One MSB-first CRC step; the narrow form lives in the low byte.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic d,
                                                  input logic wide);
        logic [CRC_W-1:0] n;
        if (wide) begin
            n = {c[CRC_W-2:0], 1'b0};
            if (d ^ c[CRC_W-1]) n = n ^ POLY16;
        end else begin
            n = {8'h00, c[6:0], 1'b0};
            if (d ^ c[7]) n[7:0] = n[7:0] ^ POLY8;
        end
        return n;
    endfunction

endpackage

// File: rtl/frm_seq.sv
module frm_seq
    import framer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             start,
    input  logic             resend,
    input  frame_cfg_t       cfg_in,
    output seg_e             seg,
    output logic [CNT_W-1:0] cnt,
    output frame_cfg_t       cfg_q,
    output logic             done,
    output logic             crc_init,
    output logic             crc_feed,
    output logic             crc_emit
);
    seg_e             seg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PID_W-1:0] pid_q;
    logic             done_q;
    logic [CNT_W-1:0] seg_bits;
    logic             last_bit;
    logic             crc_on;
    seg_e             after_ctrl;
    seg_e             after_pay;
    seg_e             seg_next;
    logic             accept;
    logic [PID_W-1:0] pid_use;

    assign crc_on     = (cfg_q.crc_sel != 2'b00);
    assign after_pay  = crc_on ? SEG_CRC : SEG_IDLE;
    assign after_ctrl = (cfg_q.len != '0) ? SEG_PAY : after_pay;
    assign accept     = (seg_q == SEG_IDLE) && start;
    assign pid_use    = resend ? pid_q : pid_q + PID_W'(1);

    always_comb begin
        case (seg_q)
            SEG_PRE:  seg_bits = CNT_W'(8);
            SEG_ADDR: seg_bits = CNT_W'({cfg_q.addr_bytes, 3'b000});
            SEG_CTRL: seg_bits = CNT_W'(CTRL_BITS);
            SEG_PAY:  seg_bits = CNT_W'({cfg_q.len, 3'b000});
            SEG_CRC:  seg_bits = cfg_q.crc_sel[1] ? CNT_W'(16) : CNT_W'(8);
            default:  seg_bits = CNT_W'(1);
        endcase
    end

    assign last_bit = (cnt_q == seg_bits - CNT_W'(1));

    always_comb begin
        case (seg_q)
            SEG_PRE:  seg_next = SEG_ADDR;
            SEG_ADDR: seg_next = cfg_q.dyn ? SEG_CTRL : after_ctrl;
            SEG_CTRL: seg_next = after_ctrl;
            SEG_PAY:  seg_next = after_pay;
            default:  seg_next = SEG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q  <= SEG_IDLE;
            cnt_q  <= '0;
            pid_q  <= '0;
            done_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cfg_q      <= cfg_in;
                cfg_q.len  <= clamp_len(cfg_in.len);
                cfg_q.pid  <= pid_use;
                pid_q      <= pid_use;
                seg_q      <= SEG_PRE;
                cnt_q      <= '0;
            end else if (seg_q != SEG_IDLE && bit_en) begin
                if (last_bit) begin
                    seg_q <= seg_next;
                    cnt_q <= '0;
                    if (seg_next == SEG_IDLE) done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign seg      = seg_q;
    assign cnt      = cnt_q;
    assign done     = done_q;
    assign crc_init = accept;
    assign crc_feed = bit_en && (seg_q == SEG_ADDR || seg_q == SEG_CTRL || seg_q == SEG_PAY);
    assign crc_emit = bit_en && (seg_q == SEG_CRC);

endmodule

// File: rtl/frm_bitsel.sv
module frm_bitsel
    import framer_pkg::*;
(
    input  seg_e              seg,
    input  logic [CNT_W-1:0]  cnt,
    input  frame_cfg_t        cfg,
    input  logic [7:0]        pay_byte,
    input  logic              crc_msb,
    output logic [PIDX_W-1:0] pay_idx,
    output logic              data_bit
);
    localparam int AIDX_W = $clog2(ADDR_BITS);
    localparam int CIDX_W = $clog2(CTRL_BITS);

    logic [CNT_W-1:0]     a_top;
    logic [CNT_W-1:0]     a_idx;
    logic                 first_addr;
    logic [CTRL_BITS-1:0] ctrl_word;
    logic [CIDX_W-1:0]    c_idx;
    logic [2:0]           b_idx;

    assign a_top      = CNT_W'({cfg.addr_bytes, 3'b000}) - CNT_W'(1);
    assign a_idx      = a_top - cnt;
    assign first_addr = cfg.addr[a_top[AIDX_W-1:0]];
    assign ctrl_word  = {cfg.len, cfg.pid, cfg.no_ack};
    assign c_idx      = CIDX_W'(CTRL_BITS - 1) - cnt[CIDX_W-1:0];
    assign b_idx      = 3'd7 - cnt[2:0];
    assign pay_idx    = (seg == SEG_PAY) ? cnt[PIDX_W+2:3] : '0;

    always_comb begin
        case (seg)
            SEG_PRE:  data_bit = first_addr ^ cnt[0];
            SEG_ADDR: data_bit = cfg.addr[a_idx[AIDX_W-1:0]];
            SEG_CTRL: data_bit = ctrl_word[c_idx];
            SEG_PAY:  data_bit = pay_byte[b_idx];
            SEG_CRC:  data_bit = crc_msb;
            default:  data_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/frm_crc.sv
module frm_crc
    import framer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic feed,
    input  logic emit,
    input  logic wide,
    input  logic data_bit,
    output logic msb
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= '1;
        end else if (feed) begin
            crc_q <= crc_step(crc_q, data_bit, wide);
        end else if (emit) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    assign msb = wide ? crc_q[CRC_W-1] : crc_q[7];

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import framer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic                  start,
    input  logic                  resend,
    input  logic [ADDR_BITS-1:0]  addr,
    input  logic [1:0]            aw_code,
    input  logic                  dyn_len,
    input  logic                  no_ack,
    input  logic [1:0]            crc_sel,
    input  logic [LEN_W-1:0]      pay_len,
    input  logic [7:0]            pay_byte,
    output logic [PIDX_W-1:0]     pay_idx,
    output logic                  tx_bit,
    output logic                  tx_valid,
    output logic                  tx_done
);
    frame_cfg_t       cfg_in;
    frame_cfg_t       cfg_q;
    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic             crc_init;
    logic             crc_feed;
    logic             crc_emit;
    logic             crc_msb;
    logic             data_bit;

    always_comb begin
        cfg_in            = '0;
        cfg_in.addr       = addr;
        cfg_in.addr_bytes = aw_bytes(aw_code);
        cfg_in.dyn        = dyn_len;
        cfg_in.no_ack     = no_ack;
        cfg_in.crc_sel    = crc_sel;
        cfg_in.len        = pay_len;
    end

    frm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .start    (start),
        .resend   (resend),
        .cfg_in   (cfg_in),
        .seg      (seg),
        .cnt      (cnt),
        .cfg_q    (cfg_q),
        .done     (tx_done),
        .crc_init (crc_init),
        .crc_feed (crc_feed),
        .crc_emit (crc_emit)
    );

    frm_bitsel u_sel (
        .seg      (seg),
        .cnt      (cnt),
        .cfg      (cfg_q),
        .pay_byte (pay_byte),
        .crc_msb  (crc_msb),
        .pay_idx  (pay_idx),
        .data_bit (data_bit)
    );

    frm_crc u_crc (
        .clk      (clk),
        .rst      (rst),
        .init     (crc_init),
        .feed     (crc_feed),
        .emit     (crc_emit),
        .wide     (cfg_q.crc_sel[1]),
        .data_bit (data_bit),
        .msb      (crc_msb)
    );

    assign tx_valid = (seg != SEG_IDLE);
    assign tx_bit   = tx_valid ? data_bit : 1'b0;

endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk
    import framer_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bit_en,
    input logic                 start,
    input logic [ADDR_BITS-1:0] addr,
    input logic [1:0]           aw_code,
    input logic [PIDX_W-1:0]    pay_idx,
    input logic                 tx_bit,
    input logic                 tx_valid,
    input logic                 tx_done
);
    logic [AB_W-1:0] nb;
    logic [5:0]      top_idx;
    logic            first_in;

    assign nb       = aw_bytes(aw_code);
    assign top_idx  = 6'({nb, 3'b000}) - 6'd1;
    assign first_in = addr[top_idx];

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_valid) |-> tx_done);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !tx_valid && $past(tx_valid));

    a_r8_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !bit_en |=> tx_valid && $stable(pay_idx));

    a_r1_preamble_first_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_bit == $past(first_in)) && $past(start));

    a_r11_quiet_output: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> !tx_bit);

endmodule

bind pkt_framer pkt_framer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .start    (start),
    .addr     (addr),
    .aw_code  (aw_code),
    .pay_idx  (pay_idx),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid),
    .tx_done  (tx_done)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic        start;
    logic        resend;
    logic [39:0] addr;
    logic [1:0]  aw_code;
    logic        dyn_len;
    logic        no_ack;
    logic [1:0]  crc_sel;
    logic [5:0]  pay_len;
    logic [7:0]  pay_byte;
    logic [4:0]  pay_idx;
    logic        tx_bit;
    logic        tx_valid;
    logic        tx_done;

    logic [7:0]  mem [32];
    logic        exp_bits [512];
    int          exp_n;
    logic        got_bits [512];
    int          got_n;
    int          mpid;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;
    assign pay_byte = mem[pay_idx];

    pkt_framer u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .start(start), .resend(resend),
        .addr(addr), .aw_code(aw_code), .dyn_len(dyn_len), .no_ack(no_ack),
        .crc_sel(crc_sel), .pay_len(pay_len), .pay_byte(pay_byte),
        .pay_idx(pay_idx), .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    // Expected packet built straight from the requirements
    task automatic build(input logic [39:0] a, input logic [1:0] awc, input logic dyn,
                         input logic na, input logic [1:0] cs, input logic [5:0] len,
                         input int pid);
        int nb;
        int lc;
        logic [15:0] c;
        int cov_start;
        logic fb;
        nb = (awc == 2'b10) ? 4 : (awc == 2'b11) ? 5 : 3;
        lc = (len > 6'd32) ? 32 : int'(len);
        exp_n = 0;
        for (int i = 0; i < 8; i++) push(a[nb*8-1] ? ~i[0] : i[0]);
        cov_start = exp_n;
        for (int i = nb*8-1; i >= 0; i--) push(a[i]);
        if (dyn) begin
            for (int i = 5; i >= 0; i--) push(lc[i]);
            push(pid[1]); push(pid[0]); push(na);
        end
        for (int k = 0; k < lc; k++)
            for (int i = 7; i >= 0; i--) push(mem[k][i]);
        c = 16'hFFFF;
        for (int j = cov_start; j < exp_n; j++) begin
            if (cs[1]) begin
                fb = exp_bits[j] ^ c[15];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end else begin
                fb = exp_bits[j] ^ c[7];
                c[7:0] = {c[6:0], 1'b0};
                if (fb) c[7:0] = c[7:0] ^ 8'h07;
            end
        end
        if (cs[1])        for (int i = 15; i >= 0; i--) push(c[i]);
        else if (cs == 2'b01) for (int i = 7; i >= 0; i--) push(c[i]);
    endtask

    // Runs one packet; gap=1 drops bit_en every third cycle; busy_at>=0 injects a start mid-packet
    task automatic run_pkt(input logic [39:0] a, input logic [1:0] awc, input logic dyn,
                           input logic na, input logic [1:0] cs, input logic [5:0] len,
                           input logic rs, input int gap, input int busy_at,
                           input string req);
        int k;
        int last_k;
        int done_k;
        int bad;
        logic be;
        if (!rs) mpid = (mpid + 1) % 4;
        build(a, awc, dyn, na, cs, len, mpid);
        @(negedge clk);
        addr = a; aw_code = awc; dyn_len = dyn; no_ack = na;
        crc_sel = cs; pay_len = len; resend = rs; start = 1'b1; bit_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        addr = ~a; aw_code = ~awc; dyn_len = ~dyn; no_ack = ~na;
        crc_sel = ~cs; pay_len = len + 6'd5; resend = 1'b0;
        check(tx_valid == 1'b1, "R8", "valid one cycle after start", int'(tx_valid), 1);
        k = 0; last_k = -10; done_k = -1; got_n = 0;
        while (done_k < 0 && k < 4000) begin
            if (tx_done) begin
                done_k = k;
                check(tx_valid == 1'b0, "R7", "valid low at done", int'(tx_valid), 0);
            end else begin
                be = (gap == 0) ? 1'b1 : ((k % 3) != 2);
                bit_en = be;
                start  = (k == busy_at);
                if (tx_valid && be) begin
                    got_bits[got_n] = tx_bit;
                    got_n++;
                    last_k = k;
                end
                @(negedge clk);
                k++;
            end
        end
        bit_en = 1'b0; start = 1'b0;
        check(got_n == exp_n, "R8", "bit count", got_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (bad < 0 && got_bits[i] !== exp_bits[i]) bad = i;
        check(bad < 0, req, "first mismatching bit index", bad, -1);
        check(done_k == last_k + 1, "R7", "done cycle", done_k, last_k + 1);
        @(negedge clk);
        check(tx_done == 1'b0, "R7", "done lasts one cycle", int'(tx_done), 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; bit_en = 1'b0; start = 1'b0; resend = 1'b0; addr = '0;
        aw_code = 2'b01; dyn_len = 1'b0; no_ack = 1'b0; crc_sel = 2'b00; pay_len = '0;
        mpid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_valid == 1'b0, "R11", "valid after reset", int'(tx_valid), 0);
        check(tx_done == 1'b0, "R11", "done after reset", int'(tx_done), 0);
        check(tx_bit == 1'b0, "R11", "bit after reset", int'(tx_bit), 0);
    endtask

    task automatic t_idle_enable;
        bit_en = 1'b1;
        repeat (5) @(negedge clk);
        check(tx_valid == 1'b0, "R8", "idle bit_en starts nothing", int'(tx_valid), 0);
        check(tx_done == 1'b0, "R8", "idle bit_en no done", int'(tx_done), 0);
        bit_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 37 + 11);
        t_reset();
        t_idle_enable();
        // R1 R2 R5: 3-byte address starting with 1, static, 8-bit CRC
        run_pkt(40'h00_00C3_5AF0, 2'b01, 1'b0, 1'b0, 2'b01, 6'd4, 1'b0, 0, -1, "R1 R2 R4 R5");
        // R1 R3 R6: 5-byte address starting with 0, dynamic, 16-bit CRC, full payload, gaps
        run_pkt(40'h3A_1122_3344, 2'b11, 1'b1, 1'b0, 2'b10, 6'd32, 1'b0, 1, -1, "R1 R3 R6 R8");
        // R2 R6: 4-byte address, CRC off, empty payload
        run_pkt(40'h00_9ABC_DEF0, 2'b10, 1'b0, 1'b0, 2'b00, 6'd0, 1'b0, 0, -1, "R2 R6");
        // R2 R3: code 00 means 3 bytes, dynamic with no_ack, empty payload
        run_pkt(40'hFF_FF12_3456, 2'b00, 1'b1, 1'b1, 2'b01, 6'd0, 1'b0, 0, -1, "R2 R3");
        // R10: resend reuses the identifier, then a new payload advances it
        run_pkt(40'hFF_FF12_3456, 2'b00, 1'b1, 1'b1, 2'b01, 6'd0, 1'b1, 0, -1, "R10 resend");
        run_pkt(40'h00_00A5_5A01, 2'b01, 1'b1, 1'b0, 2'b11, 6'd3, 1'b0, 0, -1, "R10 R6 new");
        // R9: start in the middle of a packet is ignored
        run_pkt(40'h00_00F0_0F00, 2'b01, 1'b1, 1'b0, 2'b01, 6'd2, 1'b0, 0, 20, "R9 busy start");
        run_pkt(40'h00_0012_3456, 2'b01, 1'b1, 1'b0, 2'b00, 6'd1, 1'b0, 0, -1, "R9 R10 next id");
        // R4: length above 32 is capped; wraps identifier past 3
        run_pkt(40'h81_2345_6789, 2'b11, 1'b1, 1'b1, 2'b10, 6'd45, 1'b0, 1, -1, "R4 R10 clamp");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule